// File: doc/BRIEF.md
# Round-Robin One-Hot Request Masker

This block reduces a vector of pending requests to a single one-hot grant. The search for a set request starts at the position marked by a one-hot priority vector. It moves toward the most significant bit, wraps to bit 0 past the top, and stops at the first set request it meets. The result is the request vector with every bit but one masked away. An empty request vector yields an empty grant.

The block has two faces that share the same selection logic. The first is a purely combinational selector, with the priority supplied from outside. The second is a clocked arbiter that keeps its own one-hot priority register. Each time a non-empty grant is accepted, the register moves to the position just above the granted bit, rotating from the top bit back to bit 0. A requester that has just been served therefore drops to the lowest rank. This gives a fair rotation among requesters that stay active.

Top module: `rr_onehot_arbiter`

## Requirements
- R1: Every grant (`sel_grant_o` and `arb_grant_o`) has at most one bit set, and that bit is also set in the matching request vector.
- R2: When the request vector is not all zero and the priority vector is one-hot, the grant has exactly one bit set.
- R3: When the request bit at the priority position is set, the grant equals the priority vector.
- R4: The grant is the first set request met when scanning upward from the priority position. For example, requests 01001 with priority 00010 (bit 0 is the rightmost) give grant 01000.
- R5: When no request is set at or above the priority position, the scan wraps and the grant is the lowest set request bit.
- R6: An all-zero request vector gives an all-zero grant, whatever the priority.
- R7: After reset (`rst_n` low, active low, synchronous), `arb_prio_o` has only bit 0 set.
- R8: On a clock edge with `arb_accept_i` high and a non-zero `arb_grant_o`, `arb_prio_o` becomes that grant rotated left by one, so a grant on the top bit gives priority on bit 0.
- R9: On a clock edge with `arb_accept_i` low, or with an all-zero `arb_grant_o`, `arb_prio_o` keeps its value.
- R10: `arb_grant_o` is, in the same cycle, the selection of `arb_req_i` under the current `arb_prio_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the arbiter priority register |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_req_i | input | NUM_REQ | Request vector for the standalone selector |
| sel_prio_i | input | NUM_REQ | One-hot search start for the standalone selector |
| sel_grant_o | output | NUM_REQ | One-hot grant from the standalone selector |
| arb_req_i | input | NUM_REQ | Request vector for the arbiter |
| arb_accept_i | input | 1 | Strobe: the current arbiter grant is taken |
| arb_grant_o | output | NUM_REQ | One-hot grant from the arbiter |
| arb_prio_o | output | NUM_REQ | Current one-hot priority of the arbiter |

## Verification
The bench builds the block with NUM_REQ set to 5. The width is odd and not a power of two, so the wrap from bit 4 back to bit 0 cannot be hidden by a modulo that happens to align with a power of two. At this width all 32 request patterns can be swept against all 5 priority positions of the standalone selector. The sweep reaches every upward-hit, every wrapped hit and every empty case. The arbiter runs full, sparse and empty request patterns, which walk its priority through every position, including the rotation from the top bit to the bottom one.

// File: rtl/rrm_pkg.sv
// Package rrm_pkg
// Shared types for the round-robin request masker.
// Assumes: nothing beyond SystemVerilog enum support.
package rrm_pkg;

    // Where the selected request came from during a scan.
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,   // no request set anywhere
        SRC_UPPER = 2'd1,   // hit at or above the priority position
        SRC_WRAP  = 2'd2    // hit below the priority position, after wrapping
    } rrm_src_e;

endpackage

// File: rtl/rrm_span_mask.sv
// Module rrm_span_mask
// Turns a one-hot start vector into a mask covering the start bit and every
// bit above it.
// Assumes: start_i is one-hot. With a zero start the mask is zero, and with
// several bits set the mask begins at the lowest of them.
module rrm_span_mask #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] start_i,
    output logic [WIDTH-1:0] span_o
);

    logic [WIDTH-1:0] prefix;

    // Running OR from bit 0 upward: a bit is in the span once the start has been passed.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_prefix
            if (i == 0) begin : g_first
                assign prefix[i] = start_i[i];
            end else begin : g_rest
                assign prefix[i] = prefix[i-1] | start_i[i];
            end
        end
    endgenerate

    assign span_o = prefix;

endmodule

// File: rtl/rrm_lowest_set.sv
// Module rrm_lowest_set
// Keeps only the least significant set bit of a vector and flags whether any
// bit was set.
// Assumes: nothing; an all-zero input gives an all-zero output.
module rrm_lowest_set #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic [WIDTH-1:0] first_o,
    output logic             any_o
);

    logic [WIDTH-1:0] seen_below;

    // Chain marking, for each bit, whether a lower bit is already set.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_chain
            if (i == 0) begin : g_first
                assign seen_below[i] = 1'b0;
            end else begin : g_rest
                assign seen_below[i] = seen_below[i-1] | vec_i[i-1];
            end
            assign first_o[i] = vec_i[i] & ~seen_below[i];
        end
    endgenerate

    assign any_o = seen_below[WIDTH-1] | vec_i[WIDTH-1];

endmodule

// File: rtl/rrm_rr_select.sv
// Module rrm_rr_select
// Combinational round-robin selector. It keeps the first set request met when
// scanning upward from the one-hot priority position, wrapping past the top.
// Assumes: prio_i is one-hot whenever the result is meant to be round-robin.
module rrm_rr_select
    import rrm_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] req_i,
    input  logic [WIDTH-1:0] prio_i,
    output logic [WIDTH-1:0] grant_o
);

    logic [WIDTH-1:0] span;
    logic [WIDTH-1:0] upper_req;
    logic [WIDTH-1:0] upper_pick;
    logic [WIDTH-1:0] wrap_pick;
    logic             upper_any;
    logic             wrap_any;
    rrm_src_e         src;

    rrm_span_mask #(.WIDTH(WIDTH)) u_span (
        .start_i (prio_i),
        .span_o  (span)
    );

    assign upper_req = req_i & span;

    rrm_lowest_set #(.WIDTH(WIDTH)) u_upper (
        .vec_i   (upper_req),
        .first_o (upper_pick),
        .any_o   (upper_any)
    );

    // The wrapped half of the scan resumes at bit 0. Its first set bit is the
    // lowest set request overall, and it is only used when the upper half is empty.
    rrm_lowest_set #(.WIDTH(WIDTH)) u_wrap (
        .vec_i   (req_i),
        .first_o (wrap_pick),
        .any_o   (wrap_any)
    );

    // Decide which half of the circular scan produced the hit.
    always_comb begin
        if (upper_any) begin
            src = SRC_UPPER;
        end else if (wrap_any) begin
            src = SRC_WRAP;
        end else begin
            src = SRC_NONE;
        end
    end

    // Route the selected half to the grant.
    always_comb begin
        unique case (src)
            SRC_UPPER: grant_o = upper_pick;
            SRC_WRAP:  grant_o = wrap_pick;
            default:   grant_o = '0;
        endcase
    end

endmodule

// File: rtl/rrm_prio_reg.sv
// Module rrm_prio_reg
// One-hot priority register for the arbiter. An accepted non-empty grant moves
// the priority to the bit just above it, circularly.
// Assumes: grant_i is one-hot or zero; synchronous active-low reset.
module rrm_prio_reg #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic [WIDTH-1:0] grant_i,
    output logic [WIDTH-1:0] prio_o
);

    localparam logic [WIDTH-1:0] PRIO_RESET = WIDTH'(1);

    logic [WIDTH-1:0] rotated;
    logic             advance;

    // Circular left rotation by one; with a single requester the rotation is identity.
    generate
        if (WIDTH == 1) begin : g_single
            assign rotated = grant_i;
        end else begin : g_multi
            assign rotated = {grant_i[WIDTH-2:0], grant_i[WIDTH-1]};
        end
    endgenerate

    assign advance = accept_i & (|grant_i);

    // Hold the priority, reload bit 0 on reset, advance on accepted grants.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_o <= PRIO_RESET;
        end else if (advance) begin
            prio_o <= rotated;
        end
    end

endmodule

// File: rtl/rr_onehot_arbiter.sv
// Module rr_onehot_arbiter
// Top level. It offers a standalone combinational round-robin selector with an
// external priority, and a clocked arbiter that uses the same selection
// logic with its own rotating priority register.
// Assumes: sel_prio_i is one-hot; NUM_REQ >= 1.
module rr_onehot_arbiter #(
    parameter int unsigned NUM_REQ = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] sel_req_i,
    input  logic [NUM_REQ-1:0] sel_prio_i,
    output logic [NUM_REQ-1:0] sel_grant_o,
    input  logic [NUM_REQ-1:0] arb_req_i,
    input  logic               arb_accept_i,
    output logic [NUM_REQ-1:0] arb_grant_o,
    output logic [NUM_REQ-1:0] arb_prio_o
);

    logic [NUM_REQ-1:0] arb_prio_q;
    logic [NUM_REQ-1:0] arb_grant;

    rrm_rr_select #(.WIDTH(NUM_REQ)) u_sel_path (
        .req_i   (sel_req_i),
        .prio_i  (sel_prio_i),
        .grant_o (sel_grant_o)
    );

    rrm_rr_select #(.WIDTH(NUM_REQ)) u_arb_path (
        .req_i   (arb_req_i),
        .prio_i  (arb_prio_q),
        .grant_o (arb_grant)
    );

    rrm_prio_reg #(.WIDTH(NUM_REQ)) u_prio (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (arb_accept_i),
        .grant_i  (arb_grant),
        .prio_o   (arb_prio_q)
    );

    assign arb_grant_o = arb_grant;
    assign arb_prio_o  = arb_prio_q;

endmodule

// File: rtl/rr_onehot_arbiter_chk.sv
// Module rr_onehot_arbiter_chk
// Property checker for rr_onehot_arbiter, attached with bind.
// Assumes: NUM_REQ >= 2 so that the rotation check has a distinct top bit.
module rr_onehot_arbiter_chk #(
    parameter int unsigned NUM_REQ = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] sel_req_i,
    input logic [NUM_REQ-1:0] sel_prio_i,
    input logic [NUM_REQ-1:0] sel_grant_o,
    input logic [NUM_REQ-1:0] arb_req_i,
    input logic               arb_accept_i,
    input logic [NUM_REQ-1:0] arb_grant_o,
    input logic [NUM_REQ-1:0] arb_prio_o
);

    // R1
    sel_grant_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_grant_o) && ((sel_grant_o & ~sel_req_i) == '0));

    // R1
    arb_grant_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(arb_grant_o) && ((arb_grant_o & ~arb_req_i) == '0));

    // R2
    sel_grant_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_req_i != '0) && $onehot(sel_prio_i)) |-> $onehot(sel_grant_o));

    // R3
    sel_prio_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((sel_req_i & sel_prio_i) != '0) && $onehot(sel_prio_i)) |-> (sel_grant_o == sel_prio_i));

    // R6
    sel_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_req_i == '0) |-> (sel_grant_o == '0));

    // R7
    arb_prio_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(arb_prio_o));

    // R8
    arb_prio_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_accept_i && (arb_grant_o != '0)) |=>
            (arb_prio_o == {$past(arb_grant_o[NUM_REQ-2:0]), $past(arb_grant_o[NUM_REQ-1])}));

    // R9
    arb_prio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!arb_accept_i || (arb_grant_o == '0)) |=> $stable(arb_prio_o));

    // R10
    arb_prio_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((arb_req_i & arb_prio_o) != '0) |-> (arb_grant_o == arb_prio_o));

endmodule

bind rr_onehot_arbiter rr_onehot_arbiter_chk #(.NUM_REQ(NUM_REQ)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_req_i    (sel_req_i),
    .sel_prio_i   (sel_prio_i),
    .sel_grant_o  (sel_grant_o),
    .arb_req_i    (arb_req_i),
    .arb_accept_i (arb_accept_i),
    .arb_grant_o  (arb_grant_o),
    .arb_prio_o   (arb_prio_o)
);

// File: tb/sim_rr_onehot_arbiter.sv
module sim_rr_onehot_arbiter;

    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] sel_req_i = '0;
    logic [N-1:0] sel_prio_i = 5'b00001;
    logic [N-1:0] sel_grant_o;
    logic [N-1:0] arb_req_i = '0;
    logic         arb_accept_i = 1'b0;
    logic [N-1:0] arb_grant_o;
    logic [N-1:0] arb_prio_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [N-1:0] exp_prio;

    always #2 clk = ~clk;

    rr_onehot_arbiter #(.NUM_REQ(N)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_req_i    (sel_req_i),
        .sel_prio_i   (sel_prio_i),
        .sel_grant_o  (sel_grant_o),
        .arb_req_i    (arb_req_i),
        .arb_accept_i (arb_accept_i),
        .arb_grant_o  (arb_grant_o),
        .arb_prio_o   (arb_prio_o)
    );

    // Reference: circular scan from the priority index.
    function automatic logic [N-1:0] ref_pick(input logic [N-1:0] req, input logic [N-1:0] prio);
        int start = 0;
        for (int i = 0; i < N; i++) if (prio[i]) start = i;
        for (int k = 0; k < N; k++) begin
            int idx = (start + k) % N;
            if (req[idx]) return N'(1) << idx;
        end
        return '0;
    endfunction

    function automatic logic [N-1:0] ref_next(input logic [N-1:0] g);
        for (int i = 0; i < N; i++) if (g[i]) return N'(1) << ((i + 1) % N);
        return '0;
    endfunction

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 prio after reset", arb_prio_o, 5'b00001);
        rst_n = 1'b1;
        exp_prio = 5'b00001;
        @(negedge clk);
        check("R7 prio held after release", arb_prio_o, 5'b00001);
    endtask

    task automatic t_sel_example();
        @(negedge clk);
        sel_req_i = 5'b01001; sel_prio_i = 5'b00010;
        #1 check("R4 example scan", sel_grant_o, 5'b01000);
        sel_req_i = 5'b10110; sel_prio_i = 5'b00100;
        #1 check("R3 priority bit kept", sel_grant_o, 5'b00100);
        sel_req_i = 5'b00011; sel_prio_i = 5'b01000;
        #1 check("R5 wrap to lowest", sel_grant_o, 5'b00001);
        sel_req_i = 5'b00000; sel_prio_i = 5'b10000;
        #1 check("R6 empty request", sel_grant_o, 5'b00000);
    endtask

    task automatic t_sel_sweep();
        for (int p = 0; p < N; p++) begin
            for (int r = 0; r < (1 << N); r++) begin
                @(negedge clk);
                sel_prio_i = N'(1) << p;
                sel_req_i = N'(r);
                #1 check("R1/R2 sweep", sel_grant_o, ref_pick(N'(r), N'(1) << p));
            end
        end
    endtask

    // Drive one arbiter cycle, check grant now and priority after the edge.
    task automatic arb_step(input logic [N-1:0] req, input logic acc);
        logic [N-1:0] g;
        @(negedge clk);
        arb_req_i = req; arb_accept_i = acc;
        #1;
        g = ref_pick(req, exp_prio);
        check("R10 arbiter grant", arb_grant_o, g);
        if (acc && g != '0) exp_prio = ref_next(g);
        @(posedge clk);
        #1;
        if (acc && g != '0) check("R8 priority advance", arb_prio_o, exp_prio);
        else                check("R9 priority hold", arb_prio_o, exp_prio);
    endtask

    task automatic t_arb_full();
        for (int i = 0; i < N + 2; i++) arb_step(5'b11111, 1'b1);
    endtask

    task automatic t_arb_hold();
        arb_step(5'b11111, 1'b0);
        arb_step(5'b01010, 1'b0);
        arb_step(5'b00000, 1'b1);
    endtask

    task automatic t_arb_sparse();
        arb_step(5'b10100, 1'b1);
        arb_step(5'b10100, 1'b1);
        arb_step(5'b10100, 1'b1);
        arb_step(5'b10001, 1'b1);
        arb_step(5'b10001, 1'b1);
        arb_step(5'b10001, 1'b1);
    endtask

    initial begin
        t_reset();
        t_sel_example();
        t_sel_sweep();
        t_arb_full();
        t_arb_hold();
        t_arb_sparse();
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

endmodule